// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block sits between the core of an 8-bit microcontroller and its external memory pins. The core hands it one request at a time. Each request is a code fetch, a data read or a data write, and it carries a 16-bit address. The block turns each request into a short bus cycle on a multiplexed bus. One 8-bit port first carries the low address byte and then the data byte. The two uses are told apart by an address-latch strobe. A second 8-bit port carries the high address byte. Code fetches have their own active-low program-store strobe. Data accesses use separate active-low read and write strobes.

An external-access input sets where code addresses below 1000h are fetched from. When it is high, those addresses go to a small on-chip code port and no bus cycle is made. When it is low, every code address goes out on the bus. Code addresses at 1000h and above always go out on the bus, and so do all data accesses. Code space and data space each span 64 KB.

Top module: `ebus_seq`

## Requirements
- R1: After reset, ale is 0, psen_n, rd_n and wr_n are 1, ad_oe is 0, done is 0 and req_ready is 1.
- R2: For an external access, the clock cycle after acceptance is the address phase. In that cycle ale=1, ad_oe=1, ad_out is address bits 7:0 and addr_hi is address bits 15:8.
- R3: addr_hi keeps the same value from the address phase through the strobe cycle that follows it.
- R4: An external code fetch (req_code=1) makes psen_n low for exactly the cycle after the address phase. In that cycle rd_n=wr_n=1 and ad_oe=0. req_write is ignored when req_code=1.
- R5: An external data read (req_code=0, req_write=0) makes rd_n low for the cycle after the address phase. In that cycle psen_n=1, wr_n=1 and ad_oe=0.
- R6: An external data write (req_code=0, req_write=1) makes wr_n low for the cycle after the address phase. In that cycle ad_oe=1, ad_out is the write data and psen_n=rd_n=1.
- R7: done is high for exactly one cycle, the cycle after the strobe cycle. For a read or fetch, rdata then equals the input byte sampled at the end of the strobe cycle. A write leaves rdata unchanged.
- R8: With ea=0, a code fetch at any address, including addresses below 1000h, makes an external bus cycle.
- R9: With ea=1, a code fetch at an address below 1000h makes no bus cycle: ale stays 0 and all strobes stay high. In the cycle after acceptance, rom_rd=1 and rom_addr is address bits 11:0. done follows in the next cycle with rdata equal to rom_rdata.
- R10: With ea=1, code fetches at 1000h and above go external. Data accesses go external whatever the value of ea.
- R11: req_ready is 1 only when no access is in progress, and a request is accepted only when req_valid and req_ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea | input | 1 | 1: code addresses below 1000h use the on-chip port |
| req_valid | input | 1 | Request present |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| req_write | input | 1 | Data write when req_code=0 |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read result |
| ad_out | output | 8 | Shared low-address/data port, outgoing value |
| ad_oe | output | 1 | Output enable of the shared port |
| ad_in | input | 8 | Shared port, incoming value |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rom_rd | output | 1 | On-chip code read |
| rom_addr | output | 12 | On-chip code address |
| rom_rdata | input | 8 | On-chip code data |

## Verification
The address phase appears one clock after the accepting edge. The strobe appears two clocks after it, and done with rdata three clocks after it. An on-chip fetch shows rom_rd one clock after acceptance and done two clocks after. The bench drives every request at a falling edge and counts falling edges from there, so each output is sampled half a period after the register that drives it has updated. Input bytes on ad_in and rom_rdata are set before the sampling edge, and the expected rdata is taken from what was driven there.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CODE, ST_DRD, ST_DWR, ST_INT
  } ebus_state_e;

  typedef enum logic [1:0] {
    K_CODE_EXT, K_CODE_INT, K_DATA_RD, K_DATA_WR
  } ebus_kind_e;
endpackage

// File: rtl/ebus_decode.sv
module ebus_decode
  import ebus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int ONCHIP_AW = 12
) (
  input  logic          req_code,
  input  logic          req_write,
  input  logic          ea,
  input  logic [AW-1:0] req_addr,
  output ebus_kind_e    kind
);
  logic low_code;

  generate
    if (ONCHIP_AW > 0) begin : g_onchip
      assign low_code = (req_addr[AW-1:ONCHIP_AW] == '0);
    end else begin : g_none
      assign low_code = 1'b0;
    end
  endgenerate

  always_comb begin
    if (req_code) begin
      kind = (ea && low_code) ? K_CODE_INT : K_CODE_EXT;
    end else begin
      kind = req_write ? K_DATA_WR : K_DATA_RD;
    end
  end
endmodule

// File: rtl/ebus_fsm.sv
module ebus_fsm
  import ebus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  ebus_kind_e  kind_in,
  output ebus_state_e state,
  output logic        done
);
  ebus_state_e state_d;
  ebus_kind_e  kind_q, kind_d;
  logic        done_d;

  always_comb begin
    state_d = state;
    kind_d  = kind_q;
    done_d  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          kind_d  = kind_in;
          state_d = (kind_in == K_CODE_INT) ? ST_INT : ST_ADDR;
        end
      end
      ST_ADDR: begin
        case (kind_q)
          K_DATA_RD: state_d = ST_DRD;
          K_DATA_WR: state_d = ST_DWR;
          default:   state_d = ST_CODE;
        endcase
      end
      ST_CODE, ST_DRD, ST_DWR, ST_INT: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind_q <= K_CODE_EXT;
      done   <= 1'b0;
    end else begin
      state  <= state_d;
      kind_q <= kind_d;
      done   <= done_d;
    end
  end
endmodule

// File: rtl/ebus_datapath.sv
module ebus_datapath
  import ebus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int ONCHIP_AW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  ebus_state_e          state,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  input  logic [DW-1:0]        ad_in,
  input  logic [DW-1:0]        rom_rdata,
  output logic [DW-1:0]        rdata,
  output logic [DW-1:0]        ad_out,
  output logic                 ad_oe,
  output logic [AW-DW-1:0]     addr_hi,
  output logic                 ale,
  output logic                 psen_n,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic                 rom_rd,
  output logic [ONCHIP_AW-1:0] rom_addr
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          cap_en;
  logic [DW-1:0] cap_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_comb begin
    cap_en  = (state == ST_CODE) || (state == ST_DRD) || (state == ST_INT);
    cap_val = (state == ST_INT) ? rom_rdata : ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap_en) begin
      rdata <= cap_val;
    end
  end

  always_comb begin
    ale      = (state == ST_ADDR);
    psen_n   = (state != ST_CODE);
    rd_n     = (state != ST_DRD);
    wr_n     = (state != ST_DWR);
    ad_oe    = (state == ST_ADDR) || (state == ST_DWR);
    ad_out   = (state == ST_ADDR) ? addr_q[DW-1:0] : wdata_q;
    addr_hi  = addr_q[AW-1:DW];
    rom_rd   = (state == ST_INT);
    rom_addr = addr_q[ONCHIP_AW-1:0];
  end
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int ONCHIP_AW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ea,
  input  logic                 req_valid,
  input  logic                 req_code,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 req_ready,
  output logic                 done,
  output logic [DW-1:0]        rdata,
  output logic [DW-1:0]        ad_out,
  output logic                 ad_oe,
  input  logic [DW-1:0]        ad_in,
  output logic [AW-DW-1:0]     addr_hi,
  output logic                 ale,
  output logic                 psen_n,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic                 rom_rd,
  output logic [ONCHIP_AW-1:0] rom_addr,
  input  logic [DW-1:0]        rom_rdata
);
  ebus_state_e state;
  ebus_kind_e  kind;
  logic        accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  ebus_decode #(.AW(AW), .ONCHIP_AW(ONCHIP_AW)) i_decode (
    .req_code(req_code), .req_write(req_write), .ea(ea),
    .req_addr(req_addr), .kind(kind)
  );

  ebus_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .kind_in(kind),
    .state(state), .done(done)
  );

  ebus_datapath #(.AW(AW), .DW(DW), .ONCHIP_AW(ONCHIP_AW)) i_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .state(state),
    .req_addr(req_addr), .req_wdata(req_wdata), .ad_in(ad_in),
    .rom_rdata(rom_rdata), .rdata(rdata), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_hi(addr_hi), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .rom_rd(rom_rd), .rom_addr(rom_addr)
  );
endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ale,
  input logic             psen_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic             rom_rd,
  input logic             ad_oe,
  input logic             done,
  input logic             req_ready,
  input logic [AW-DW-1:0] addr_hi
);
  a_r2_ale_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!psen_n || !rd_n || !wr_n));

  a_r3_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> $stable(addr_hi));

  a_r4_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ale, !psen_n, !rd_n, !wr_n, rom_rd}) <= 1);

  a_r5_read_releases_port: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !ad_oe);

  a_r7_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!psen_n || !rd_n || !wr_n || rom_rd));

  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || rom_rd) |-> !req_ready);
endmodule

bind ebus_seq ebus_seq_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
  .wr_n(wr_n), .rom_rd(rom_rd), .ad_oe(ad_oe), .done(done),
  .req_ready(req_ready), .addr_hi(addr_hi)
);

// File: tb/test_ebus_seq.sv
`timescale 1ns/1ps
module test_ebus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ea = 1'b0, req_valid = 1'b0, req_code = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ad_in = '0, rom_rdata = '0;
  logic        req_ready, done, ad_oe, ale, psen_n, rd_n, wr_n, rom_rd;
  logic [7:0]  rdata, ad_out, addr_hi;
  logic [11:0] rom_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] last_rdata = '0;

  always #2.5 clk = ~clk;

  ebus_seq i_ebus_seq (
    .clk(clk), .rst_n(rst_n), .ea(ea), .req_valid(req_valid),
    .req_code(req_code), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rdata(rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .rom_rd(rom_rd),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic is_internal(input logic code, input logic e, input logic [15:0] a);
    return code && e && (a < 16'h1000);
  endfunction

  // strobe pattern {ale, psen_n, rd_n, wr_n}
  function automatic logic [3:0] exp_strobe(input logic code, input logic wr);
    if (code) return 4'b0011;
    return wr ? 4'b0110 : 4'b0101;
  endfunction

  task automatic access(input logic code, input logic wr, input logic e,
                        input logic [15:0] a, input logic [7:0] wd);
    logic [7:0] bus_byte, rom_byte;
    bus_byte = 8'($urandom);
    rom_byte = 8'($urandom);
    @(negedge clk);
    ea = e; req_code = code; req_write = wr; req_addr = a; req_wdata = wd;
    req_valid = 1'b1; ad_in = bus_byte; rom_rdata = rom_byte;
    check("R11 ready when idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    check("R11 busy not ready", 32'(req_ready), 32'd0);
    if (is_internal(code, e, a)) begin
      check("R9 internal no bus", 32'({ale, psen_n, rd_n, wr_n}), 32'h7);
      check("R9 rom_rd", 32'(rom_rd), 32'd1);
      check("R9 rom_addr", 32'(rom_addr), 32'(a[11:0]));
      @(negedge clk);
      check("R9 done", 32'(done), 32'd1);
      check("R9 rdata", 32'(rdata), 32'(rom_byte));
      last_rdata = rom_byte;
    end else begin
      check("R2 ale/oe", 32'({ale, ad_oe}), 32'h3);
      check("R2 ad_out low addr", 32'(ad_out), 32'(a[7:0]));
      check("R2 addr_hi", 32'(addr_hi), 32'(a[15:8]));
      if (code) check("R8 R10 external code", 32'(ale), 32'd1);
      @(negedge clk);
      check(code ? "R4 fetch strobe" : (wr ? "R6 write strobe" : "R5 read strobe"),
            32'({ale, psen_n, rd_n, wr_n}), 32'(exp_strobe(code, wr)));
      check("R3 addr_hi hold", 32'(addr_hi), 32'(a[15:8]));
      check("R7 no early done", 32'(done), 32'd0);
      if (!code && wr) begin
        check("R6 oe", 32'(ad_oe), 32'd1);
        check("R6 write data", 32'(ad_out), 32'(wd));
      end else begin
        check(code ? "R4 port released" : "R5 port released", 32'(ad_oe), 32'd0);
      end
      @(negedge clk);
      check("R7 done", 32'(done), 32'd1);
      if (!(!code && wr)) last_rdata = bus_byte;
      check("R7 rdata", 32'(rdata), 32'(last_rdata));
    end
    @(negedge clk);
    check("R7 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4051));
    #1;
    check("R1 reset strobes", 32'({ale, psen_n, rd_n, wr_n, ad_oe}), 32'b01110);
    check("R1 reset done/ready", 32'({done, req_ready}), 32'b01);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'({ale, psen_n, rd_n, wr_n, done, req_ready}), 32'b011101);
    // directed corners
    access(1'b1, 1'b0, 1'b0, 16'h0000, 8'h00);   // R8
    access(1'b1, 1'b0, 1'b0, 16'h0FFF, 8'h00);   // R8
    access(1'b1, 1'b0, 1'b1, 16'h0FFF, 8'h00);   // R9
    access(1'b1, 1'b1, 1'b1, 16'h0000, 8'h5A);   // R9 write bit ignored
    access(1'b1, 1'b0, 1'b1, 16'h1000, 8'h00);   // R10
    access(1'b1, 1'b1, 1'b0, 16'hFFFF, 8'hA5);   // R4 write bit ignored
    access(1'b0, 1'b0, 1'b1, 16'h0010, 8'h00);   // R10 data external
    access(1'b0, 1'b1, 1'b1, 16'h0020, 8'hC3);   // R6 R10
    access(1'b0, 1'b1, 1'b0, 16'hABCD, 8'h3C);   // R6 R7 rdata kept
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      a = ($urandom % 2) ? 16'($urandom % 16'h2000) : 16'($urandom);
      access(1'($urandom), 1'($urandom), 1'($urandom), a, 8'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule